// File: doc/BRIEF.md
# Per-Processor Device Interrupt Router

This block fans a bank of device interrupt request lines out to a small group of processors. A single request register is shared by all processors and holds one bit per source. Each processor owns a mask register and a masked-request view, and the view always equals that processor's mask ANDed with the shared request register. Devices raise and drop individual request lines through a narrow event port that carries a line number and a direction. Processors read and write their registers over a 64-bit register bus.

Each processor has one level-sensitive interrupt output. The block does not rebuild that output by scanning the whole view. Instead it keeps a per-processor posted vector and changes only the bits touched by an event. A bit is posted when its mask bit turns on while the request is active, or when the request turns on while the mask bit is set. A bit is withdrawn when it leaves the masked view. The output is the registered OR of the posted vector. The block does not encode priority and does not produce vectors.

Top module: `irq_router`

## Requirements
- R1: After reset, every mask, request and masked-request register reads zero, and every processor interrupt output is low.
- R2: A read of a processor's masked-request register returns that processor's mask ANDed with the request register.
- R3: A mask write that newly sets bit n, while request bit n is active, raises that processor's interrupt output.
- R4: A mask write that clears every bit still active in the view drops that processor's interrupt output. Bits that stay active keep it high.
- R5: A device assert event on line n sets request bit n. It raises the interrupt of every processor whose mask has bit n set, and of no other processor.
- R6: A device deassert event on line n clears request bit n and withdraws source n from every processor. If request bit n is already clear, the event is spurious and changes no register and no output.
- R7: The register index is the byte address shifted right by 6, so the low 6 address bits are ignored. Indices 0 to 3 are the masks of processors 0 to 3 and are read/write. Indices 4 to 7 are the masked-request views of processors 0 to 3 and are read-only. Index 8 is the request register and is read-only.
- R8: The size code is the log2 of the access width in bytes, and only code 3 (64 bits) is legal. Any other size returns zero, pulses the error output for exactly one cycle, and a write with it changes nothing.
- R9: A read of an unmapped index, or a write to a read-only or unmapped index, returns zero, pulses the error output, and changes no register.
- R10: Each interrupt output is a registered level. It follows a state change one clock after the edge that updates the registers, and it is high exactly when that processor's masked view is non-zero.
- R11: A device event and a mask write in the same cycle both take effect. The resulting view equals the new mask ANDed with the new request register.
- R12: Every bus access returns a response one cycle later (the edge that samples the request), carrying the read data and the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_valid_i | input | 1 | Device event strobe |
| dev_assert_i | input | 1 | 1 = raise line, 0 = drop line |
| dev_line_i | input | LINE_W (6) | Source line number |
| bus_valid_i | input | 1 | Register access strobe |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W (12) | Byte address within the block |
| bus_size_i | input | 2 | log2 of access bytes |
| bus_wdata_i | input | NUM_SRC (64) | Write data |
| bus_rvalid_o | output | 1 | Response strobe |
| bus_rdata_o | output | NUM_SRC (64) | Read data, zero on error or write |
| bus_err_o | output | 1 | One-cycle error pulse |
| cpu_irq_o | output | NUM_CPU (4) | Per-processor interrupt level |

## Verification
A posted vector that drifts from the masked view shows up in two ways. An interrupt output can stay high while a read of the view returns zero, or it can stay low while the view is non-zero. Either mismatch is visible one clock after the event that caused the drift. A request bit lost on a spurious deassert, or a mask changed by a rejected write, shows up on the very next read of that register. It also shows up on the outputs once a later event involves that source.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_HALF  = 2'd1,
      SZ_WORD  = 2'd2,
      SZ_DWORD = 2'd3
   } acc_size_e;

   localparam int IDX_SHIFT = 6;
   localparam int MASK_BASE = 0;
   localparam int VIEW_BASE = 4;
   localparam int REQ_INDEX = 8;
   localparam int MAX_CPU   = 4;

endpackage

// File: rtl/irq_req_reg.sv
module irq_req_reg #(
   parameter int NUM_SRC = 64,
   localparam int LINE_W = $clog2(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               dev_valid_i,
   input  logic               dev_assert_i,
   input  logic [LINE_W-1:0]  dev_line_i,
   output logic [NUM_SRC-1:0] req_q_o,
   output logic [NUM_SRC-1:0] req_next_o,
   output logic [NUM_SRC-1:0] rise_o
);

   logic [NUM_SRC-1:0] req_q;
   logic [NUM_SRC-1:0] req_next;
   logic [NUM_SRC-1:0] line_hot;

   always_comb begin
      line_hot = '0;
      line_hot[dev_line_i] = 1'b1;
   end

   always_comb begin
      req_next = req_q;
      if (dev_valid_i) begin
         if (dev_assert_i)
            req_next = req_q | line_hot;
         else if ((req_q & line_hot) != '0)
            req_next = req_q & ~line_hot;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) req_q <= '0;
      else        req_q <= req_next;
   end

   assign rise_o     = (dev_valid_i && dev_assert_i) ? line_hot : '0;
   assign req_q_o    = req_q;
   assign req_next_o = req_next;

   // R6: a deassert of an already clear line leaves the register alone
   p_spurious_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_valid_i && !dev_assert_i && !req_q[dev_line_i]) |=> (req_q == $past(req_q)));

   // R5: an assert event leaves its line set
   p_line_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_valid_i && dev_assert_i) |=> req_q[$past(dev_line_i)]);

endmodule

// File: rtl/irq_cpu_slice.sv
module irq_cpu_slice #(
   parameter int NUM_SRC = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mask_we_i,
   input  logic [NUM_SRC-1:0] wdata_i,
   input  logic [NUM_SRC-1:0] req_q_i,
   input  logic [NUM_SRC-1:0] req_next_i,
   input  logic [NUM_SRC-1:0] rise_i,
   output logic [NUM_SRC-1:0] mask_o,
   output logic [NUM_SRC-1:0] view_o,
   output logic               irq_o
);

   logic [NUM_SRC-1:0] mask_q, mask_next;
   logic [NUM_SRC-1:0] view_q, view_next;
   logic [NUM_SRC-1:0] posted_q, posted_next;
   logic [NUM_SRC-1:0] post_set, post_clr;
   logic               irq_q;

   always_comb begin
      mask_next   = mask_we_i ? wdata_i : mask_q;
      view_next   = mask_next & req_next_i;
      // incremental update: only bits that changed are touched
      post_set    = (mask_next & ~mask_q & req_next_i) | (rise_i & mask_next);
      post_clr    = view_q & ~view_next;
      posted_next = (posted_q | post_set) & ~post_clr;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q   <= '0;
         view_q   <= '0;
         posted_q <= '0;
         irq_q    <= 1'b0;
      end else begin
         mask_q   <= mask_next;
         view_q   <= view_next;
         posted_q <= posted_next;
         irq_q    <= |posted_q;
      end
   end

   assign mask_o = mask_q;
   assign view_o = view_q;
   assign irq_o  = irq_q;

   // R2: incremental posted vector tracks the recomputed view
   p_posted_matches_view_r2: assert property (@(posedge clk) disable iff (!rst_n)
      posted_q == view_q);

   // R2: the view register equals mask AND shared request
   p_view_is_and_r2: assert property (@(posedge clk) disable iff (!rst_n)
      view_q == (mask_q & req_q_i));

   // R10: output is the registered OR of the posted vector
   p_irq_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_q == $past(|posted_q)));

   // R9: mask only moves on an enabled write
   p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_we_i |=> (mask_q == $past(mask_q)));

endmodule

// File: rtl/irq_csr_decode.sv
module irq_csr_decode
   import irq_router_pkg::*;
#(
   parameter int NUM_CPU = 4,
   parameter int NUM_SRC = 64,
   parameter int ADDR_W  = 12,
   localparam int IDX_W  = ADDR_W - IDX_SHIFT
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            bus_valid_i,
   input  logic                            bus_write_i,
   input  logic [ADDR_W-1:0]               bus_addr_i,
   input  logic [1:0]                      bus_size_i,
   input  logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_i,
   input  logic [NUM_CPU-1:0][NUM_SRC-1:0] view_i,
   input  logic [NUM_SRC-1:0]              req_i,
   output logic [NUM_CPU-1:0]              mask_we_o,
   output logic                            rvalid_o,
   output logic [NUM_SRC-1:0]              rdata_o,
   output logic                            err_o
);

   logic [IDX_W-1:0]   idx;
   logic [IDX_SHIFT-1:0] unused_low;
   logic               size_ok;
   logic               hit_mask, hit_view, hit_req;
   logic               bad;
   logic [NUM_SRC-1:0] rd_mux;
   logic               rvalid_q, err_q;
   logic [NUM_SRC-1:0] rdata_q;

   assign idx        = bus_addr_i[ADDR_W-1:IDX_SHIFT];
   assign unused_low = bus_addr_i[IDX_SHIFT-1:0];
   assign size_ok    = (acc_size_e'(bus_size_i) == SZ_DWORD);
   assign hit_mask   = (int'(idx) >= MASK_BASE) && (int'(idx) < MASK_BASE + NUM_CPU);
   assign hit_view   = (int'(idx) >= VIEW_BASE) && (int'(idx) < VIEW_BASE + NUM_CPU);
   assign hit_req    = (int'(idx) == REQ_INDEX);
   assign bad        = !size_ok || !(hit_mask || hit_view || hit_req) ||
                       (bus_write_i && !hit_mask);

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_we
      assign mask_we_o[c] = bus_valid_i && bus_write_i && size_ok &&
                            (int'(idx) == MASK_BASE + c);
   end

   always_comb begin
      rd_mux = '0;
      if (!bus_write_i && !bad) begin
         if (hit_req) rd_mux = req_i;
         for (int c = 0; c < NUM_CPU; c++) begin
            if (int'(idx) == MASK_BASE + c) rd_mux = mask_i[c];
            if (int'(idx) == VIEW_BASE + c) rd_mux = view_i[c];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid_q <= 1'b0;
         err_q    <= 1'b0;
         rdata_q  <= '0;
      end else begin
         rvalid_q <= bus_valid_i;
         err_q    <= bus_valid_i && bad;
         rdata_q  <= bus_valid_i ? rd_mux : '0;
      end
   end

   assign rvalid_o = rvalid_q;
   assign err_o    = err_q;
   assign rdata_o  = rdata_q;

   // R8: error only accompanies a response
   p_err_with_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> rvalid_q);

   // R9: erroring access returns zero
   p_err_zero_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> (rdata_q == '0));

   // R12: one response per access, one cycle later
   p_resp_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid_i |=> rvalid_q);

endmodule

// File: rtl/irq_router.sv
module irq_router
   import irq_router_pkg::*;
#(
   parameter int NUM_CPU = 4,
   parameter int NUM_SRC = 64,
   parameter int ADDR_W  = 12,
   localparam int LINE_W = $clog2(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               dev_valid_i,
   input  logic               dev_assert_i,
   input  logic [LINE_W-1:0]  dev_line_i,
   input  logic               bus_valid_i,
   input  logic               bus_write_i,
   input  logic [ADDR_W-1:0]  bus_addr_i,
   input  logic [1:0]         bus_size_i,
   input  logic [NUM_SRC-1:0] bus_wdata_i,
   output logic               bus_rvalid_o,
   output logic [NUM_SRC-1:0] bus_rdata_o,
   output logic               bus_err_o,
   output logic [NUM_CPU-1:0] cpu_irq_o
);

   if (NUM_CPU < 1 || NUM_CPU > MAX_CPU) begin : g_bad_cpu
      $error("irq_router: NUM_CPU must lie in 1..4");
   end
   if (NUM_SRC != 64) begin : g_bad_src
      $error("irq_router: NUM_SRC must match the 64-bit register bus");
   end
   if (ADDR_W < IDX_SHIFT + 4) begin : g_bad_addr
      $error("irq_router: ADDR_W too narrow for the register map");
   end

   logic [NUM_SRC-1:0]              req_q, req_next, rise;
   logic [NUM_CPU-1:0]              mask_we;
   logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_all, view_all;

   irq_req_reg #(.NUM_SRC(NUM_SRC)) u_req (
      .clk          (clk),
      .rst_n        (rst_n),
      .dev_valid_i  (dev_valid_i),
      .dev_assert_i (dev_assert_i),
      .dev_line_i   (dev_line_i),
      .req_q_o      (req_q),
      .req_next_o   (req_next),
      .rise_o       (rise)
   );

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      irq_cpu_slice #(.NUM_SRC(NUM_SRC)) u_slice (
         .clk        (clk),
         .rst_n      (rst_n),
         .mask_we_i  (mask_we[c]),
         .wdata_i    (bus_wdata_i),
         .req_q_i    (req_q),
         .req_next_i (req_next),
         .rise_i     (rise),
         .mask_o     (mask_all[c]),
         .view_o     (view_all[c]),
         .irq_o      (cpu_irq_o[c])
      );
   end

   irq_csr_decode #(
      .NUM_CPU (NUM_CPU),
      .NUM_SRC (NUM_SRC),
      .ADDR_W  (ADDR_W)
   ) u_csr (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_valid_i (bus_valid_i),
      .bus_write_i (bus_write_i),
      .bus_addr_i  (bus_addr_i),
      .bus_size_i  (bus_size_i),
      .mask_i      (mask_all),
      .view_i      (view_all),
      .req_i       (req_q),
      .mask_we_o   (mask_we),
      .rvalid_o    (bus_rvalid_o),
      .rdata_o     (bus_rdata_o),
      .err_o       (bus_err_o)
   );

endmodule

// File: tb/irq_router_bench.sv
`timescale 1ns/1ps
module irq_router_bench;

   localparam int NC = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dev_valid = 1'b0, dev_assert = 1'b0;
   logic [5:0]  dev_line = '0;
   logic        bus_valid = 1'b0, bus_write = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [1:0]  bus_size = 2'd3;
   logic [63:0] bus_wdata = '0;
   logic        bus_rvalid, bus_err;
   logic [63:0] bus_rdata;
   logic [NC-1:0] cpu_irq;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 0;

   logic [63:0] m_mask [NC];
   logic [63:0] m_req;

   logic [63:0]   s_rdata;
   logic          s_err1, s_err2, s_rvalid;
   logic [NC-1:0] s_irq_early;

   always #10 clk = ~clk;

   irq_router u_irq_router (
      .clk(clk), .rst_n(rst_n),
      .dev_valid_i(dev_valid), .dev_assert_i(dev_assert), .dev_line_i(dev_line),
      .bus_valid_i(bus_valid), .bus_write_i(bus_write), .bus_addr_i(bus_addr),
      .bus_size_i(bus_size), .bus_wdata_i(bus_wdata),
      .bus_rvalid_o(bus_rvalid), .bus_rdata_o(bus_rdata), .bus_err_o(bus_err),
      .cpu_irq_o(cpu_irq)
   );

   function automatic logic [NC-1:0] exp_irq();
      logic [NC-1:0] v;
      for (int c = 0; c < NC; c++) v[c] = |(m_mask[c] & m_req);
      return v;
   endfunction

   function automatic bit exp_err(bit wr, int idx, logic [1:0] sz);
      if (sz != 2'd3) return 1;
      if (wr) return !(idx < NC);
      return !(idx < 2*NC || idx == 8);
   endfunction

   function automatic logic [63:0] exp_read(bit wr, int idx, logic [1:0] sz);
      if (wr || exp_err(wr, idx, sz)) return '0;
      if (idx < NC) return m_mask[idx];
      if (idx < 2*NC) return m_mask[idx-NC] & m_req;
      return m_req;
   endfunction

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   endtask

   // drive one cycle of stimulus, sample response after the edge and irq one edge later
   task automatic cycle_op(bit bv, bit wr, int idx, logic [5:0] low, logic [1:0] sz,
                           logic [63:0] wd, bit dv, bit da, logic [5:0] ln);
      bus_valid = bv; bus_write = wr; bus_addr = {idx[5:0], low};
      bus_size = sz; bus_wdata = wd;
      dev_valid = dv; dev_assert = da; dev_line = ln;
      @(negedge clk);
      s_rdata = bus_rdata; s_err1 = bus_err; s_rvalid = bus_rvalid; s_irq_early = cpu_irq;
      bus_valid = 0; dev_valid = 0;
      @(negedge clk);
      s_err2 = bus_err;
      // update model: device first, then mask write
      if (dv) m_req[ln] = da;
      if (bv && wr && !exp_err(wr, idx, sz)) m_mask[idx] = wd;
   endtask

   task automatic bus_chk(string tag, bit wr, int idx, logic [5:0] low,
                          logic [1:0] sz, logic [63:0] wd);
      logic [63:0] er;
      bit ee;
      er = exp_read(wr, idx, sz);
      ee = exp_err(wr, idx, sz);
      cycle_op(1, wr, idx, low, sz, wd, 0, 0, '0);
      check({tag, " rdata"}, s_rdata, er);
      check({tag, " err"}, 64'(s_err1), 64'(ee));
      check({tag, " rvalid R12"}, 64'(s_rvalid), 64'd1);
   endtask

   task automatic irq_chk(string tag);
      check({tag, " irq"}, 64'(cpu_irq), 64'(exp_irq()));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [NC-1:0] pre;
      void'($urandom(32'd20240611));
      m_req = '0;
      for (int c = 0; c < NC; c++) m_mask[c] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 irq after reset", 64'(cpu_irq), 64'd0);
      bus_chk("R1 mask0", 0, 0, 0, 2'd3, 0);
      bus_chk("R1 view3", 0, 7, 0, 2'd3, 0);
      bus_chk("R1 req", 0, 8, 0, 2'd3, 0);

      // R5 assert with no mask: req set, no irq
      cycle_op(0, 0, 0, 0, 3, 0, 1, 1, 6'd5);
      irq_chk("R5 unmasked assert");
      bus_chk("R5 req bit5", 0, 8, 0, 2'd3, 0);

      // R3 + R10: mask write raises irq0 one edge after update
      pre = cpu_irq;
      cycle_op(1, 1, 0, 0, 3, 64'h20, 0, 0, '0);
      check("R10 irq not yet moved", 64'(s_irq_early), 64'(pre));
      irq_chk("R3 mask set raises");
      bus_chk("R2 view0", 0, 4, 0, 2'd3, 0);

      // R7 low address bits ignored
      bus_chk("R7 mask1 via offset", 1, 1, 6'h2A, 2'd3, 64'h220);
      irq_chk("R7 irq1");
      bus_chk("R7 view1 via offset", 0, 5, 6'h3F, 2'd3, 0);

      // R5 line 9 reaches cpu1 only
      cycle_op(0, 0, 0, 0, 3, 0, 1, 1, 6'd9);
      irq_chk("R5 line9");
      // R6 deassert line5 drops cpu0, cpu1 stays on bit 9
      cycle_op(0, 0, 0, 0, 3, 0, 1, 0, 6'd5);
      irq_chk("R6 deassert withdraws");
      // R6 spurious deassert
      cycle_op(0, 0, 0, 0, 3, 0, 1, 0, 6'd5);
      irq_chk("R6 spurious");
      bus_chk("R6 req after spurious", 0, 8, 0, 2'd3, 0);
      // R4 mask clear drops cpu1
      bus_chk("R4 clear mask1", 1, 1, 0, 2'd3, 64'h0);
      irq_chk("R4 drop");

      // R8 illegal size
      bus_chk("R8 bad size write", 1, 2, 0, 2'd2, '1);
      check("R8 err single cycle", 64'(s_err2), 64'd0);
      bus_chk("R8 mask2 unchanged", 0, 2, 0, 2'd3, 0);
      bus_chk("R8 bad size read", 0, 8, 0, 2'd1, 0);
      irq_chk("R8 irq");

      // R9 unmapped / read-only
      bus_chk("R9 unmapped read", 0, 9, 0, 2'd3, 0);
      bus_chk("R9 write req", 1, 8, 0, 2'd3, '1);
      bus_chk("R9 write view", 1, 4, 0, 2'd3, '1);
      bus_chk("R9 req unchanged", 0, 8, 0, 2'd3, 0);
      irq_chk("R9 irq");

      // R11 simultaneous event and mask write
      cycle_op(1, 1, 3, 0, 3, 64'h10_0000, 1, 1, 6'd20);
      irq_chk("R11 combined");
      bus_chk("R11 view3", 0, 7, 0, 2'd3, 0);

      // random mix
      for (int i = 0; i < 400; i++) begin
         int r;
         int idx;
         logic [63:0] d;
         r = $urandom % 10;
         idx = $urandom % 10;
         d = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
         case (r)
            0, 1, 2: cycle_op(0, 0, 0, 0, 3, 0, 1, 1, 6'($urandom % 64));
            3, 4:    cycle_op(0, 0, 0, 0, 3, 0, 1, 0, 6'($urandom % 64));
            5, 6:    bus_chk("R3 R4 rnd mask write", 1, $urandom % NC, 6'($urandom), 2'd3, d);
            7, 8:    bus_chk("R2 R7 rnd read", 0, idx, 6'($urandom), 2'($urandom), 0);
            default: cycle_op(1, 1, $urandom % NC, 0, 3, d, 1, 1'($urandom), 6'($urandom % 64));
         endcase
         irq_chk("R10 rnd");
      end
      for (int c = 0; c < 2*NC; c++) bus_chk("R2 final sweep", 0, c, 0, 2'd3, 0);

      finish_run();
   end

endmodule